// File: doc/BRIEF.md
# CAN Receive Message Queue with Mailbox Window

This block holds frames that a CAN receiver has already decoded and hands them to the CPU one at a time. The queue has four entries. The CPU never addresses the entries directly. It sees only the oldest entry, through a fixed window laid out like a mailbox: an identifier word, a length code and eight data bytes. After the CPU has read an entry, it discards it by writing the key value 0xFF to a separate pointer register. Reading the window never changes the queue.

A control register holds the enable bit and the full-queue policy, and shows a read-only empty flag. When a frame arrives at a full queue, the policy decides what happens. In keep-oldest mode the new frame is thrown away. In overwrite mode the new frame replaces the newest stored entry. Both cases raise a sticky overrun flag. Every frame that is stored raises a receive flag. That flag, qualified by an enable bit, drives the receive interrupt line.

The CPU side is a simple synchronous register bus. Reads are combinational from the word address. Writes take a byte of data and take effect on the clock edge.

Top module: `canrx_msgq`

## Requirements
- R1: The queue stores up to DEPTH (default 4) frames in arrival order. The window shows the oldest frame as follows:
  - word 0: the identifier word exactly as received (bit 31 extended flag, bit 30 remote flag, standard ID in 28:18, extended ID in 28:0);
  - word 1: the length code in bits 3:0;
  - word 2: data bytes 0..3, with byte 0 in bits 7:0;
  - word 3: data bytes 4..7, with byte 4 in bits 7:0.
- R2: A write of 0xFF to the pointer register (word 5) removes the oldest entry at that clock edge. A write of any other value to word 5 leaves the queue unchanged.
- R3: The control register is word 4:
  - bit 0 is the enable, read/write;
  - bit 1 is the policy, read/write (1 = keep oldest, 0 = overwrite newest);
  - bit 7 is the empty flag, read-only.
  After reset the control register reads 0x80.
- R4: A frame presented while the enable bit is 0 is not stored and sets neither the receive flag nor the overrun flag.
- R5: In keep-oldest mode, a frame that arrives at a full queue with no removal in the same cycle is discarded. The stored entries stay unchanged and the overrun flag sets.
- R6: In overwrite mode, a frame that arrives at a full queue with no removal in the same cycle replaces the newest entry. Both the overrun flag and the receive flag set.
- R7: A removal write while the queue is empty is ignored. All four window words read zero while the queue is empty.
- R8: The status register is word 6. Bit 4 is the receive flag and bit 2 is the overrun flag (`rx_ovr` mirrors bit 2).
  - The receive flag sets when a frame is written into storage.
  - Writing 0 to a flag's bit clears that flag. Writing 1 has no effect.
  - A set in the same cycle wins over a clear.
- R9: The interrupt enable register is word 7, with the enable in bit 4. `irq_rx` is high exactly when the receive flag and this enable are both 1.
- R10: When a frame arrives at a full queue in the same cycle as a removal write, the frame is stored and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_store | input | 1 | Strobe: a decoded frame is present this cycle |
| frm_id | input | 32 | Identifier word of the incoming frame |
| frm_dlc | input | 4 | Length code of the incoming frame |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq_rx | output | 1 | Receive interrupt |
| rx_ovr | output | 1 | Sticky overrun flag |

## Verification
Every stored state in this block changes on the clock edge that samples the stimulus. This applies to a frame strobe, a removal write and a register write. Each of these results is therefore due one edge later: the window contents, the empty flag, both status flags and `irq_rx`. Register reads are combinational and carry no extra latency.

The bench drives each stimulus between edges and advances its behavioural queue model at the same edge. It then reads all eight register words and both outputs 2 ns after that edge, so every comparison sees exactly one edge of effect. Directed sequences cover the full-queue and empty-queue corners, and a random phase follows them.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

    typedef struct packed {
        logic [31:0] id;
        logic [3:0]  dlc;
        logic [63:0] data;
    } canrx_frame_t;

    typedef enum logic [2:0] {
        RA_ID   = 3'd0,
        RA_DLC  = 3'd1,
        RA_DLO  = 3'd2,
        RA_DHI  = 3'd3,
        RA_CTRL = 3'd4,
        RA_PTR  = 3'd5,
        RA_ISR  = 3'd6,
        RA_IER  = 3'd7
    } canrx_reg_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_MODE_BIT  = 1;
    localparam int CTRL_EMPTY_BIT = 7;
    localparam int ISR_OVR_BIT    = 2;
    localparam int ISR_RX_BIT     = 4;
    localparam int IER_RX_BIT     = 4;
    localparam logic [7:0] POP_KEY = 8'hFF;

    function automatic logic [7:0] ctrl_byte(input logic empty, input logic mode,
                                             input logic en);
        logic [7:0] b;
        b = '0;
        b[CTRL_EMPTY_BIT] = empty;
        b[CTRL_MODE_BIT]  = mode;
        b[CTRL_EN_BIT]    = en;
        return b;
    endfunction

    function automatic logic [7:0] isr_byte(input logic rx, input logic ovr);
        logic [7:0] b;
        b = '0;
        b[ISR_RX_BIT]  = rx;
        b[ISR_OVR_BIT] = ovr;
        return b;
    endfunction

endpackage

// File: rtl/canrx_store.sv
module canrx_store
    import canrx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop_req,
    input  logic         keep_old,
    input  canrx_frame_t frame_in,
    output canrx_frame_t head,
    output logic         empty,
    output logic         wrote,
    output logic         lost
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [PW-1:0] wr_ptr, rd_ptr, newest_ptr;
    logic [CW-1:0] count;
    canrx_frame_t  mem [DEPTH];

    logic pop_ok, full_now, wr_new, wr_ovw;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        pop_ok     = pop_req && (count != '0);
        full_now   = (count == FULL_CNT) && !pop_ok;
        wr_new     = push && !full_now;
        wr_ovw     = push && full_now && !keep_old;
        lost       = push && full_now;
        wrote      = wr_new || wr_ovw;
        newest_ptr = (wr_ptr == '0) ? LAST_IDX : wr_ptr - PW'(1);
        empty      = (count == '0);
        head       = empty ? '0 : mem[rd_ptr];
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if ((wr_new && wr_ptr == PW'(i)) ||
                         (wr_ovw && newest_ptr == PW'(i))) begin
                mem[i] <= frame_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_new) wr_ptr <= step(wr_ptr);
            if (pop_ok) rd_ptr <= step(rd_ptr);
            count <= count + CW'(wr_new) - CW'(pop_ok);
        end
    end

    // R1: occupancy never exceeds the depth
    a_r1_bounded: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R5: keep-oldest mode leaves a full queue untouched
    a_r5_keep_full: assert property (@(posedge clk) disable iff (rst)
        (push && !pop_req && keep_old && count == FULL_CNT)
        |=> (count == FULL_CNT && $stable(head) && $stable(wr_ptr)));

    // R6: overwrite mode keeps the read side still
    a_r6_overwrite_hold: assert property (@(posedge clk) disable iff (rst)
        (push && !pop_req && !keep_old && count == FULL_CNT)
        |=> (count == FULL_CNT && $stable(rd_ptr)));

    // R7: removal on an empty queue changes nothing
    a_r7_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push && count == '0) |=> (count == '0 && $stable(rd_ptr)));

    // R10: removal and arrival together at a full queue stay full
    a_r10_swap_full: assert property (@(posedge clk) disable iff (rst)
        (push && pop_req && count == FULL_CNT) |=> (count == FULL_CNT));

endmodule

// File: rtl/canrx_regs.sv
module canrx_regs
    import canrx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_we,
    input  logic [2:0]   bus_addr,
    input  logic [7:0]   bus_wdata,
    input  canrx_frame_t head,
    input  logic         empty,
    input  logic         wrote,
    input  logic         lost,
    output logic [31:0]  bus_rdata,
    output logic         fifo_en,
    output logic         keep_old,
    output logic         pop_req,
    output logic         irq_rx,
    output logic         rx_ovr
);
    logic rx_flag, ovr_flag, ier_rx;
    logic wr_ctrl, wr_isr, wr_ier;

    always_comb begin
        wr_ctrl = bus_we && (bus_addr == RA_CTRL);
        wr_isr  = bus_we && (bus_addr == RA_ISR);
        wr_ier  = bus_we && (bus_addr == RA_IER);
        pop_req = bus_we && (bus_addr == RA_PTR) && (bus_wdata == POP_KEY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_en  <= 1'b0;
            keep_old <= 1'b0;
            ier_rx   <= 1'b0;
            rx_flag  <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                fifo_en  <= bus_wdata[CTRL_EN_BIT];
                keep_old <= bus_wdata[CTRL_MODE_BIT];
            end
            if (wr_ier) ier_rx <= bus_wdata[IER_RX_BIT];
            rx_flag  <= (rx_flag && !(wr_isr && !bus_wdata[ISR_RX_BIT])) || wrote;
            ovr_flag <= (ovr_flag && !(wr_isr && !bus_wdata[ISR_OVR_BIT])) || lost;
        end
    end

    always_comb begin
        irq_rx = rx_flag && ier_rx;
        rx_ovr = ovr_flag;
        unique case (bus_addr)
            RA_ID:   bus_rdata = head.id;
            RA_DLC:  bus_rdata = {28'd0, head.dlc};
            RA_DLO:  bus_rdata = head.data[31:0];
            RA_DHI:  bus_rdata = head.data[63:32];
            RA_CTRL: bus_rdata = {24'd0, ctrl_byte(empty, keep_old, fifo_en)};
            RA_ISR:  bus_rdata = {24'd0, isr_byte(rx_flag, ovr_flag)};
            RA_IER:  bus_rdata = {27'd0, ier_rx, 4'd0};
            default: bus_rdata = '0;
        endcase
    end

    // R8: the receive flag only rises after a frame was stored
    a_r8_rx_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_flag) |-> $past(wrote));

    // R8: the overrun flag only rises after a frame was lost or replaced
    a_r8_ovr_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> $past(lost));

    // R8: a stored frame always leaves the receive flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        wrote |=> rx_flag);

endmodule

// File: rtl/canrx_msgq.sv
module canrx_msgq
    import canrx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frm_store,
    input  logic [31:0] frm_id,
    input  logic [3:0]  frm_dlc,
    input  logic [63:0] frm_data,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_rx,
    output logic        rx_ovr
);
    canrx_frame_t frame_in, head;
    logic fifo_en, keep_old, pop_req, empty, wrote, lost, push;

    always_comb begin
        frame_in.id   = frm_id;
        frame_in.dlc  = frm_dlc;
        frame_in.data = frm_data;
        push          = frm_store && fifo_en;
    end

    canrx_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop_req  (pop_req),
        .keep_old (keep_old),
        .frame_in (frame_in),
        .head     (head),
        .empty    (empty),
        .wrote    (wrote),
        .lost     (lost)
    );

    canrx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .head      (head),
        .empty     (empty),
        .wrote     (wrote),
        .lost      (lost),
        .bus_rdata (bus_rdata),
        .fifo_en   (fifo_en),
        .keep_old  (keep_old),
        .pop_req   (pop_req),
        .irq_rx    (irq_rx),
        .rx_ovr    (rx_ovr)
    );

    // R4: a frame offered while disabled touches neither storage nor flags
    a_r4_disabled_drop: assert property (@(posedge clk) disable iff (rst)
        (frm_store && !fifo_en) |-> (!wrote && !lost));

endmodule

// File: tb/canrx_msgq_test.sv
module canrx_msgq_test;
    localparam int DEPTH = 4;

    typedef struct {
        logic [31:0] id;
        logic [3:0]  dlc;
        logic [63:0] d;
    } fr_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_store = 1'b0;
    logic [31:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_rx, rx_ovr;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    fr_t q[$];
    bit m_en, m_mode, m_rx, m_ov, m_ier;

    canrx_msgq #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .frm_store(frm_store), .frm_id(frm_id),
        .frm_dlc(frm_dlc), .frm_data(frm_data), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_rx(irq_rx), .rx_ovr(rx_ovr)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic model_apply();
        bit pop, push;
        bit nrx, nov;
        fr_t f;
        nrx = m_rx;
        nov = m_ov;
        pop  = bus_we && bus_addr == 3'd5 && bus_wdata == 8'hFF && q.size() != 0;
        push = frm_store && m_en;
        if (bus_we && bus_addr == 3'd6) begin
            if (!bus_wdata[4]) nrx = 0;
            if (!bus_wdata[2]) nov = 0;
        end
        if (pop) void'(q.pop_front());
        if (push) begin
            f.id = frm_id; f.dlc = frm_dlc; f.d = frm_data;
            if (q.size() < DEPTH) begin
                q.push_back(f);
                nrx = 1;
            end else begin
                nov = 1;
                if (!m_mode) begin
                    q[q.size()-1] = f;
                    nrx = 1;
                end
            end
        end
        if (bus_we && bus_addr == 3'd4) begin
            m_en = bus_wdata[0];
            m_mode = bus_wdata[1];
        end
        if (bus_we && bus_addr == 3'd7) m_ier = bus_wdata[4];
        m_rx = nrx;
        m_ov = nov;
    endtask

    task automatic compare_all();
        logic [31:0] v;
        fr_t h;
        bit emp;
        emp = (q.size() == 0);
        if (emp) begin h.id = '0; h.dlc = '0; h.d = '0; end
        else h = q[0];
        rd(3'd0, v); chk("R1 window id", v, h.id);
        rd(3'd1, v); chk("R1 window dlc", v, {28'd0, h.dlc});
        rd(3'd2, v); chk("R1 window data lo", v, h.d[31:0]);
        rd(3'd3, v); chk("R1 window data hi", v, h.d[63:32]);
        rd(3'd4, v); chk("R3 control", v, {24'd0, emp, 5'd0, m_mode, m_en});
        rd(3'd5, v); chk("R2 pointer reads zero", v, 32'd0);
        rd(3'd6, v); chk("R8 status", v, {27'd0, m_rx, 1'b0, m_ov, 2'b00});
        rd(3'd7, v); chk("R9 irq enable", v, {27'd0, m_ier, 4'd0});
        chk("R9 irq_rx", {31'd0, irq_rx}, {31'd0, m_rx & m_ier});
        chk("R8 rx_ovr", {31'd0, rx_ovr}, {31'd0, m_ov});
    endtask

    task automatic tick();
        model_apply();
        @(posedge clk);
        #2;
        frm_store = 0;
        bus_we = 0;
        compare_all();
    endtask

    task automatic set_frame(input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] d);
        frm_store = 1; frm_id = id; frm_dlc = dlc; frm_data = d;
    endtask

    task automatic set_wr(input logic [2:0] a, input logic [7:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic push_f(input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] d);
        set_frame(id, dlc, d);
        tick();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        set_wr(a, d);
        tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #2;
        rst = 0;
        compare_all();
        rd(3'd4, v); chk("R3 reset control", v, 32'h80);

        // R4: disabled queue drops the frame silently
        push_f(32'h0123_0000, 4'd2, 64'h55AA);
        rd(3'd4, v); chk("R4 still empty", v, 32'h80);
        rd(3'd6, v); chk("R4 no flag", v, 32'h0);

        wr(3'd4, 8'h01);
        // R1: standard, extended and remote frames
        push_f({3'b000, 11'h123, 18'd0}, 4'd8, 64'h0807060504030201);
        rd(3'd2, v); chk("R1 byte0 low", v, 32'h04030201);
        rd(3'd3, v); chk("R1 byte4 low", v, 32'h08070605);
        push_f({3'b100, 29'h1ABC_DE0F}, 4'd3, 64'h0000_0000_00C0_FFEE);
        push_f({3'b010, 11'h7FF, 18'd0}, 4'd0, 64'h0);
        push_f({3'b000, 11'h001, 18'd0}, 4'd1, 64'h11);
        // R6: overwrite newest when full
        push_f({3'b000, 11'h2EE, 18'd0}, 4'd4, 64'hEEEE);
        chk("R6 overrun flag", {31'd0, rx_ovr}, 32'd1);
        rd(3'd0, v); chk("R6 head kept oldest", v, {3'b000, 11'h123, 18'd0});
        wr(3'd5, 8'hFF); wr(3'd5, 8'hFF); wr(3'd5, 8'hFF);
        rd(3'd0, v); chk("R6 newest replaced", v, {3'b000, 11'h2EE, 18'd0});
        wr(3'd5, 8'hFF);
        // R7: pop on empty ignored, window zero
        wr(3'd5, 8'hFF);
        rd(3'd4, v); chk("R7 empty flag", v, 32'h81);
        rd(3'd0, v); chk("R7 window zero", v, 32'h0);
        // R2: non-key pointer write ignored
        push_f(32'h8000_0042, 4'd2, 64'h1234);
        wr(3'd5, 8'hFE);
        rd(3'd0, v); chk("R2 non-key ignored", v, 32'h8000_0042);
        wr(3'd5, 8'hFF);
        rd(3'd4, v); chk("R2 key removes", v, 32'h81);
        // R5: keep-oldest mode
        wr(3'd4, 8'h03);
        wr(3'd6, 8'h00);
        for (int i = 1; i <= 4; i++) push_f(32'h1000 + i, 4'(i), 64'(i));
        push_f(32'hDEAD, 4'd7, 64'h77);
        chk("R5 overrun flag", {31'd0, rx_ovr}, 32'd1);
        rd(3'd0, v); chk("R5 head kept", v, 32'h1001);
        wr(3'd5, 8'hFF); wr(3'd5, 8'hFF); wr(3'd5, 8'hFF);
        rd(3'd0, v); chk("R5 new frame discarded", v, 32'h1004);
        // R10: pop and push together at full
        for (int i = 1; i <= 3; i++) push_f(32'h2000 + i, 4'd1, 64'h0);
        wr(3'd6, 8'h00);
        set_frame(32'h3333, 4'd5, 64'h5);
        set_wr(3'd5, 8'hFF);
        tick();
        chk("R10 no overrun", {31'd0, rx_ovr}, 32'd0);
        rd(3'd0, v); chk("R10 head advanced", v, 32'h2001);
        wr(3'd5, 8'hFF); wr(3'd5, 8'hFF); wr(3'd5, 8'hFF);
        rd(3'd0, v); chk("R10 frame stored", v, 32'h3333);
        // R8: writing ones has no effect, set wins over clear
        wr(3'd6, 8'h14);
        rd(3'd6, v); chk("R8 ones keep flag", v, 32'h10);
        wr(3'd5, 8'hFF);
        set_frame(32'h4444, 4'd0, 64'h0);
        set_wr(3'd6, 8'h00);
        tick();
        rd(3'd6, v); chk("R8 set wins", v, 32'h10);
        // R9: interrupt gating
        chk("R9 irq masked", {31'd0, irq_rx}, 32'd0);
        wr(3'd7, 8'h10);
        chk("R9 irq raised", {31'd0, irq_rx}, 32'd1);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int r;
            if ($urandom % 2 == 0)
                set_frame($urandom, 4'($urandom), {$urandom, $urandom});
            r = $urandom % 8;
            case (r)
                0, 1: set_wr(3'd5, 8'hFF);
                2: set_wr(3'd5, 8'($urandom));
                3: set_wr(3'd4, {6'd0, 1'($urandom), ($urandom % 5 != 0)});
                4: set_wr(3'd6, 8'($urandom));
                5: set_wr(3'd7, 8'($urandom));
                default: ;
            endcase
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule